// File: doc/BRIEF.md
# Interrupt Hold-Off Controller

This block drives a device's external interrupt request pin from a set of internal interrupt sources. Each source has its own enable. The enabled sources are ORed together, and the result reaches the pin only while a master enable is set. After the host has been interrupted and the request goes away, the block keeps the pin quiet for a programmable hold-off time. An interrupt that arrives during that time waits and is delivered when the time runs out. A power-management interrupt does not wait: it reaches the pin at any time.

The hold-off time is counted in 10 µs units. A free-running prescaler derives the unit from a parameterised clock frequency. The host sees one 32-bit configuration and status word at a single word offset on a simple synchronous register bus. Through that word the host sets the hold-off length, cancels a running hold-off, or starts a fresh one. It can also read whether a hold-off is running and whether any enabled source is active.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: After synchronous reset, `irq_pin` is 0, the hold-off length is 0, no hold-off is running, and a read of the configuration word returns 0.
- R2: The hold-off length sits in bits 31:24 of the configuration word and can be read and written. The word answers only at offset `CFG_ADDR`: writes to any other offset change nothing, and reads of any other offset return 0. Read data appears one cycle after the address is presented.
- R3: Bit 12 reads 1 whenever any source with its enable set is active, whatever the master enable or hold-off state. `irq_pin` is 1 one cycle after an enabled source is active while `irq_master_en` is 1 and no hold-off is running.
- R4: A hold-off starts when a delivered request goes away while the hold-off length is non-zero. While it runs, bit 13 reads 1 and enabled sources cannot drive `irq_pin`. A source still active when it ends is delivered then.
- R5: The hold-off counter loads the length and drops by one on each prescaler tick. A tick occurs once every CLK_HZ/100000 clock cycles, so a length of N holds the pin low for between N-1 and N tick periods plus a cycle of latency.
- R6: A write with bits 31:24 equal to 0 ends any running hold-off at once. A pending request then reaches `irq_pin` on the following cycle.
- R7: A write with bit 14 set restarts the hold-off from the length in that same write, whether or not a hold-off was running. Bit 14 always reads 0.
- R8: `pm_irq` drives `irq_pin` to 1 on the next cycle, whatever the hold-off, the master enable and the sources are doing.
- R9: Bits 23:15, bit 14 and bits 11:0 of the configuration word read 0.
- R10: Writing a new non-zero length without bit 14 leaves a running hold-off untouched. The new length applies to every hold-off that starts later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_active | input | NSRC | Level of each internal interrupt source |
| src_enable | input | NSRC | Per-source enable mask |
| irq_master_en | input | 1 | Master enable for source interrupts on the pin |
| pm_irq | input | 1 | Power-management interrupt, bypasses the hold-off |
| reg_addr | input | ADDR_W | Host register word offset |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered host read data |
| irq_pin | output | 1 | Registered interrupt request pin level |

## Verification
A wrong hold-off count shows at the ports within one tick period. The pin rises too early or too late after a pending source, and bit 13 reads the wrong value on the next read. A lost or spurious start of a hold-off changes `irq_pin` on the very next cycle, because the pin is registered straight off the gating term. The reference model runs beside the design and compares the pin and the read data on every clock. It therefore catches a counter or prescaler slip on the first cycle the slip reaches either output.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;
  localparam int CFG_W    = 32;
  localparam int LEN_W    = 8;
  localparam int LEN_LSB  = 24;
  localparam int RST_BIT  = 14;
  localparam int HOLD_BIT = 13;
  localparam int ANY_BIT  = 12;
  localparam int TICK_HZ  = 100_000;

  function automatic logic [CFG_W-1:0] pack_cfg(input logic [LEN_W-1:0] len,
                                                 input logic hold,
                                                 input logic any_src);
    logic [CFG_W-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[HOLD_BIT] = hold;
    w[ANY_BIT] = any_src;
    return w;
  endfunction
endpackage

// File: rtl/irq_holdoff_tick.sv
module irq_holdoff_tick #(
  parameter int CLK_HZ = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  import irq_holdoff_pkg::*;
  localparam int TPC   = (CLK_HZ / TICK_HZ) > 0 ? (CLK_HZ / TICK_HZ) : 1;
  localparam int PRE_W = (TPC > 1) ? $clog2(TPC) : 1;

  logic [PRE_W-1:0] pre_cnt;

  generate
    if (TPC > 1) begin : g_div
      assign tick = (pre_cnt == PRE_W'(TPC - 1));
      always_ff @(posedge clk) begin
        if (rst || tick) pre_cnt <= '0;
        else             pre_cnt <= pre_cnt + 1'b1;
      end
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R5
    end else begin : g_nodiv
      assign tick = 1'b1;
      always_ff @(posedge clk) pre_cnt <= '0;
    end
  endgenerate
endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cancel,
  input  logic             restart,
  input  logic [LEN_W-1:0] restart_len,
  input  logic             start,
  input  logic [LEN_W-1:0] cur_len,
  output logic             active
);
  logic [LEN_W-1:0] cnt;

  assign active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (cancel)         cnt <= '0;
    else if (restart)        cnt <= restart_len;
    else if (start)          cnt <= cur_len;
    else if (tick && active) cnt <= cnt - 1'b1;
  end

  AST_TICK_DEC: assert property (@(posedge clk) disable iff (rst)
    (active && tick && !cancel && !restart) |=> (cnt == $past(cnt) - 1'b1)); // R5
  AST_CANCEL_REL: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !active); // R6
  AST_RESTART_LD: assert property (@(posedge clk) disable iff (rst)
    (restart && !cancel) |=> (cnt == $past(restart_len))); // R7
endmodule

// File: rtl/irq_holdoff_regs.sv
module irq_holdoff_regs #(
  parameter int ADDR_W   = 8,
  parameter int CFG_ADDR = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              hold_active,
  input  logic              any_src,
  output logic [7:0]        len_q,
  output logic              wr_cancel,
  output logic              wr_restart,
  output logic [7:0]        wr_len,
  output logic [31:0]       reg_rdata
);
  import irq_holdoff_pkg::*;

  logic hit;
  assign hit        = (reg_addr == ADDR_W'(CFG_ADDR));
  assign wr_len     = reg_wdata[LEN_LSB +: LEN_W];
  assign wr_cancel  = hit && reg_wr && (wr_len == '0);
  assign wr_restart = hit && reg_wr && reg_wdata[RST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (hit && reg_wr) len_q <= wr_len;
      reg_rdata <= hit ? pack_cfg(len_q, hold_active, any_src) : '0;
    end
  end

  AST_LEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (hit && reg_wr) |=> (len_q == $past(wr_len))); // R2
  AST_OFFADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(hit) |-> (reg_rdata == '0)); // R2
endmodule

// File: rtl/irq_holdoff_ctrl.sv
module irq_holdoff_ctrl #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int NSRC     = 8,
  parameter int ADDR_W   = 8,
  parameter int CFG_ADDR = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_active,
  input  logic [NSRC-1:0]   src_enable,
  input  logic              irq_master_en,
  input  logic              pm_irq,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_pin
);
  import irq_holdoff_pkg::*;

  logic             tick;
  logic             any_src;
  logic             hold_active;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] wr_len;
  logic             wr_cancel;
  logic             wr_restart;
  logic             gated_q;
  logic             gated_nx;
  logic             start;

  assign any_src  = |(src_active & src_enable);
  assign gated_nx = any_src && irq_master_en && !hold_active;
  assign start    = gated_q && !gated_nx && !hold_active;

  irq_holdoff_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  irq_holdoff_timer #(.LEN_W(LEN_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .cancel     (wr_cancel),
    .restart    (wr_restart),
    .restart_len(wr_len),
    .start      (start),
    .cur_len    (len_q),
    .active     (hold_active)
  );

  irq_holdoff_regs #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .hold_active(hold_active),
    .any_src    (any_src),
    .len_q      (len_q),
    .wr_cancel  (wr_cancel),
    .wr_restart (wr_restart),
    .wr_len     (wr_len),
    .reg_rdata  (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gated_q <= 1'b0;
      irq_pin <= 1'b0;
    end else begin
      gated_q <= gated_nx;
      irq_pin <= pm_irq || gated_nx;
    end
  end

  AST_HOLD_MUTES: assert property (@(posedge clk) disable iff (rst)
    ($past(hold_active) && !$past(pm_irq)) |-> !irq_pin); // R4
  AST_PM_BYPASS: assert property (@(posedge clk) disable iff (rst)
    $past(pm_irq) |-> irq_pin); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!$past(pm_irq) && !$past(any_src)) |-> !irq_pin); // R3
endmodule

// File: tb/irq_holdoff_ctrl_tb_top.sv
module irq_holdoff_ctrl_tb_top;
  localparam int CLK_HZ = 500_000;
  localparam int TPC    = CLK_HZ / 100_000;
  localparam int NSRC   = 8;
  localparam int ADDR_W = 8;
  localparam int CFG    = 21;
  localparam int WDOG   = 100_000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSRC-1:0]   src_active = '0;
  logic [NSRC-1:0]   src_enable = '0;
  logic              irq_master_en = 1'b0;
  logic              pm_irq = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq_pin;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  irq_holdoff_ctrl #(.CLK_HZ(CLK_HZ), .NSRC(NSRC), .ADDR_W(ADDR_W), .CFG_ADDR(CFG)) dut_i (
    .clk(clk), .rst(rst), .src_active(src_active), .src_enable(src_enable),
    .irq_master_en(irq_master_en), .pm_irq(pm_irq), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin)
  );

  // behavioural reference model
  int m_pre, m_hold, m_len;
  bit m_req, m_pin;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    bit tick, anys, req_nx, wr_hit;
    int wlen;
    cyc++;
    if (rst) begin
      m_pre = 0; m_hold = 0; m_len = 0; m_req = 0; m_pin = 0; m_rd = 0;
    end else begin
      tick   = (m_pre == TPC - 1);
      anys   = (src_active & src_enable) != 0;
      req_nx = anys && irq_master_en && (m_hold == 0);
      wr_hit = reg_wr && (reg_addr == CFG);
      wlen   = int'(reg_wdata[31:24]);
      m_rd   = (reg_addr == CFG) ?
               ((m_len << 24) | ((m_hold != 0) ? 32'h2000 : 0) | (anys ? 32'h1000 : 0)) : 0;
      if (wr_hit && wlen == 0)                   m_hold = 0;
      else if (wr_hit && reg_wdata[14])          m_hold = wlen;
      else if (m_req && !req_nx && m_hold == 0)  m_hold = m_len;
      else if (tick && m_hold > 0)               m_hold = m_hold - 1;
      if (wr_hit) m_len = wlen;
      m_pin = pm_irq || req_nx;
      m_req = req_nx;
      m_pre = tick ? 0 : m_pre + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_run++;
      if (irq_pin !== m_pin) begin
        n_fail++;
        $display("FAIL R3 model pin at cycle %0d: act=%0b exp=%0b", cyc, irq_pin, m_pin);
      end
      n_run++;
      if (reg_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R2 model rdata at cycle %0d: act=%h exp=%h", cyc, reg_rdata, m_rd);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      n_fail++;
      $display("FAIL watchdog expired: act=%0d exp<=%0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = CFG;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    reg_addr = a;
    @(negedge clk);
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (irq_pin == 1'b0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    reg_addr = CFG;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pin after reset", {31'b0, irq_pin}, 32'h0);
    rd(CFG);
    chk("R1 cfg after reset", reg_rdata, 32'h0);

    wr(CFG, 32'h0300_0000);
    rd(CFG);
    chk("R2 length readback", reg_rdata, 32'h0300_0000);

    src_enable = 8'h0F; src_active = 8'h02;
    tick_n(2);
    chk("R3 any-source flag with master off", reg_rdata, 32'h0300_1000);
    chk("R3 pin off while master off", {31'b0, irq_pin}, 32'h0);
    src_active = 8'h20;
    tick_n(2);
    chk("R3 masked source ignored", reg_rdata, 32'h0300_0000);
    src_active = 8'h02; irq_master_en = 1'b1;
    tick_n(2);
    chk("R3 pin on", {31'b0, irq_pin}, 32'h1);

    src_active = 8'h00;
    tick_n(2);
    chk("R4 hold flag set", {31'b0, reg_rdata[13]}, 32'h1);
    src_active = 8'h01;
    low_len(n);
    chk("R4 pending delivered", {31'b0, irq_pin}, 32'h1);
    n_run++;
    if (n < 2 * TPC - 2 || n > 3 * TPC + 2) begin
      n_fail++;
      $display("FAIL R5 hold length: act=%0d exp=%0d..%0d", n, 2 * TPC - 2, 3 * TPC + 2);
    end

    src_active = 8'h00;
    tick_n(2);
    pm_irq = 1'b1;
    tick_n(1);
    chk("R8 pm bypasses hold", {31'b0, irq_pin}, 32'h1);
    pm_irq = 1'b0;
    src_active = 8'h01;
    tick_n(2);
    chk("R4 source held during hold", {31'b0, irq_pin}, 32'h0);
    wr(CFG, 32'h0);
    tick_n(1);
    chk("R6 zero write releases", {31'b0, irq_pin}, 32'h1);

    src_active = 8'h00;
    tick_n(2);
    wr(CFG, 32'h0200_4000);
    rd(CFG);
    chk("R7 restart sets hold, bit 14 reads 0", reg_rdata, 32'h0200_2000);
    tick_n(3 * TPC + 4);
    rd(CFG);
    chk("R7 restart hold expired", reg_rdata, 32'h0200_0000);

    wr(CFG, 32'h0400_0000);
    src_active = 8'h01;
    tick_n(2);
    src_active = 8'h00;
    tick_n(2);
    wr(CFG, 32'h0100_0000);
    rd(CFG);
    chk("R10 running hold kept", reg_rdata, 32'h0100_2000);
    tick_n(5 * TPC + 4);
    src_active = 8'h01;
    tick_n(2);
    src_active = 8'h00;
    tick_n(1);
    src_active = 8'h01;
    low_len(n);
    n_run++;
    if (n > TPC + 3) begin
      n_fail++;
      $display("FAIL R10 new length used: act=%0d exp<=%0d", n, TPC + 3);
    end

    src_active = 8'h00;
    wr(CFG, 32'h0);
    wr(CFG, 32'hFFFF_FFFF);
    rd(CFG);
    chk("R9 reserved bits read 0", reg_rdata, 32'hFF00_2000);
    wr(CFG, 32'h0);
    wr(8'h00, 32'h0500_4000);
    rd(CFG);
    chk("R2 off-address write ignored", reg_rdata, 32'h0);
    rd(8'h00);
    chk("R2 off-address read is 0", reg_rdata, 32'h0);

    tick_n(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule